// File: doc/BRIEF.md
# Super-block compressed cache set lookup

This block finds one memory block inside a single set of a compressed last-level cache. Tags in the set are kept per super-block: one tag covers four aligned neighbouring 64-byte blocks and holds a separate coherence state and compressed flag for each of the four members. Whether one member or all four are resident, the tag has the same format. Data is held in 16-byte sub-blocks that may sit in any slot of the set, in any order and not next to each other. Each slot carries a back pointer: a valid bit, the index of the owning tag within the set and the 2-bit member index. An uncompressed block occupies four sub-blocks and a compressed block fewer. Because the data is located only by back-pointer matching, a block whose compressed size changes never forces other sub-blocks to move.

A request presents a block address. In the request cycle the super tags and back pointers are compared in parallel. The lowest-numbered tag whose address matches and whose member state is valid wins. The back pointers that name that tag and member form a slot mask, which is registered. In the next cycle the data array is read through that mask. Matching sub-blocks are packed in ascending slot order into a four-lane 64-byte bus with a lane-valid mask, a hit flag, the member's compressed flag and an error flag.

A small controller sequences the two steps. Its states are ST_IDLE (no lookup pending) and ST_SELECT (a compared request waits for its data gather). It has four transitions: IDLE to SELECT on a request, SELECT to SELECT on a back-to-back request, SELECT to IDLE when no request arrives, and IDLE to IDLE otherwise. A new request is accepted every cycle.

Top module: `sbc_lookup`

## Requirements
- R1: A request hits when some tag's stored super address equals req_addr[31:2] and that tag's state for member req_addr[1:0] is non-zero. State 0 means invalid and the state field of member m of tag t is tag_state[(4t+m)*2 +: 2]. rsp_hit reports the result.
- R2: When several tags qualify under R1, the one with the lowest tag index is used. A tag whose address matches but whose member state is invalid is skipped.
- R3: rsp_valid is high for exactly one cycle, two rising edges after the edge that samples req_valid. Requests on consecutive cycles each get their own response on consecutive cycles.
- R4: On a hit, the selected sub-blocks are the slots s with bp_valid[s] set, bp_tag[4s +: 4] equal to the winning tag index and bp_blk[2s +: 2] equal to the member index. They fill lanes in ascending slot order, lane i being rsp_data[128i +: 128]. Bit i of rsp_lane_vld is set when lane i is filled, and unfilled lanes read zero.
- R5: Tags and back pointers are sampled on the request edge. sub_data is sampled one edge later, on the selection edge.
- R6: rsp_comp is the winning tag's compressed flag for the member, tag_comp[4t+m], on a hit and 0 on a miss.
- R7: On a miss, rsp_lane_vld, rsp_data, rsp_err and rsp_comp are all zero.
- R8: rsp_err is set on a hit when more than four slots match, or when an uncompressed member matches other than exactly four slots. With more than four matches only the first four in slot order are delivered and rsp_lane_vld is 4'hF.
- R9: While rst_n is low, every output is zero.
- R10: Between responses, rsp_hit, rsp_comp, rsp_lane_vld, rsp_data and rsp_err hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | 32 | Block address; bits 1:0 pick the member |
| tag_addr | input | 480 | Super address of each of the 16 tags, 30 bits each |
| tag_state | input | 128 | 2-bit state per member per tag, 0 = invalid |
| tag_comp | input | 64 | Compressed flag per member per tag |
| bp_valid | input | 64 | Slot holds data |
| bp_tag | input | 256 | Owning tag index per slot, 4 bits each |
| bp_blk | input | 128 | Owning member index per slot, 2 bits each |
| sub_data | input | 8192 | Data array of the set, 128 bits per slot |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_comp | output | 1 | Member is stored compressed |
| rsp_lane_vld | output | 4 | Filled output lanes |
| rsp_data | output | 512 | Gathered sub-blocks, lane 0 lowest |
| rsp_err | output | 1 | Sub-block count inconsistent with the member |

## Verification
The lookup is first tried on a hand-built set. In that set two tags share a super address, the sub-blocks are scattered out of order, and decoy slots carry a wrong tag, a wrong member or a cleared valid bit. The cases there tell apart priority against state masking, ordered gathering against slot-position gathering, and the error rules for compressed, uncompressed and over-full members. Back-to-back requests separate per-request responses from a merged one. Changing the data array between the request edge and the selection edge shows which edge supplies the data. A long run with randomly refilled arrays, drawn from a small pool of super addresses, then mixes hits, misses and odd match counts against the cycle-by-cycle reference model.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int MEMBERS = 4;
    localparam int MIDX_W  = 2;
    localparam int LANES   = 4;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SELECT = 1'b1
    } sel_state_t;
endpackage

// File: rtl/sbc_tag_match.sv
module sbc_tag_match
    import sbc_pkg::*;
#(
    parameter int NUM_TAGS = 16,
    parameter int BLK_AW   = 32,
    parameter int ST_W     = 2,
    localparam int TIDX_W  = $clog2(NUM_TAGS),
    localparam int STAG_W  = BLK_AW - MIDX_W
)(
    input  logic [BLK_AW-1:0]                 addr_i,
    input  logic [NUM_TAGS*STAG_W-1:0]        tag_addr_i,
    input  logic [NUM_TAGS*MEMBERS*ST_W-1:0]  tag_state_i,
    input  logic [NUM_TAGS*MEMBERS-1:0]       tag_comp_i,
    output logic                              hit_o,
    output logic [TIDX_W-1:0]                 tidx_o,
    output logic                              comp_o
);
    logic [MIDX_W-1:0]   midx;
    logic [NUM_TAGS-1:0] cand;

    assign midx = addr_i[MIDX_W-1:0];

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        logic          addr_eq;
        logic [ST_W-1:0] mstate;
        assign addr_eq = (tag_addr_i[t*STAG_W +: STAG_W] == addr_i[BLK_AW-1:MIDX_W]);
        assign mstate  = tag_state_i[(t*MEMBERS + int'(midx))*ST_W +: ST_W];
        assign cand[t] = addr_eq && (mstate != '0);
    end

    always_comb begin
        hit_o  = 1'b0;
        tidx_o = '0;
        for (int t = NUM_TAGS - 1; t >= 0; t--) begin
            if (cand[t]) begin
                hit_o  = 1'b1;
                tidx_o = TIDX_W'(t);
            end
        end
    end

    assign comp_o = hit_o && tag_comp_i[int'(tidx_o)*MEMBERS + int'(midx)];
endmodule

// File: rtl/sbc_bp_match.sv
module sbc_bp_match
    import sbc_pkg::*;
#(
    parameter int NUM_TAGS = 16,
    parameter int NUM_SUBS = 64,
    localparam int TIDX_W  = $clog2(NUM_TAGS)
)(
    input  logic                       en_i,
    input  logic [TIDX_W-1:0]          tidx_i,
    input  logic [MIDX_W-1:0]          midx_i,
    input  logic [NUM_SUBS-1:0]        bp_valid_i,
    input  logic [NUM_SUBS*TIDX_W-1:0] bp_tag_i,
    input  logic [NUM_SUBS*MIDX_W-1:0] bp_blk_i,
    output logic [NUM_SUBS-1:0]        match_o
);
    for (genvar s = 0; s < NUM_SUBS; s++) begin : g_slot
        logic tag_eq;
        logic blk_eq;
        assign tag_eq     = (bp_tag_i[s*TIDX_W +: TIDX_W] == tidx_i);
        assign blk_eq     = (bp_blk_i[s*MIDX_W +: MIDX_W] == midx_i);
        assign match_o[s] = en_i && bp_valid_i[s] && tag_eq && blk_eq;
    end
endmodule

// File: rtl/sbc_gather.sv
module sbc_gather
    import sbc_pkg::*;
#(
    parameter int NUM_SUBS = 64,
    parameter int SUB_W    = 128,
    localparam int CNT_W   = $clog2(NUM_SUBS + 1),
    localparam int OUT_W   = LANES * SUB_W
)(
    input  logic                      hit_i,
    input  logic                      comp_i,
    input  logic [NUM_SUBS-1:0]       match_i,
    input  logic [NUM_SUBS*SUB_W-1:0] sub_data_i,
    output logic [LANES-1:0]          lane_vld_o,
    output logic [OUT_W-1:0]          data_o,
    output logic                      err_o
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt    = '0;
        data_o = '0;
        for (int s = 0; s < NUM_SUBS; s++) begin
            if (match_i[s]) begin
                for (int l = 0; l < LANES; l++) begin
                    if (cnt == CNT_W'(l)) begin
                        data_o[l*SUB_W +: SUB_W] = sub_data_i[s*SUB_W +: SUB_W];
                    end
                end
                cnt = cnt + CNT_W'(1);
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_vld_o[l] = (cnt > CNT_W'(l));
    end

    assign err_o = hit_i && ((cnt > CNT_W'(LANES)) ||
                             (!comp_i && (cnt != CNT_W'(LANES))));
endmodule

// File: rtl/sbc_lookup.sv
module sbc_lookup
    import sbc_pkg::*;
#(
    parameter int NUM_TAGS = 16,
    parameter int NUM_SUBS = 64,
    parameter int BLK_AW   = 32,
    parameter int SUB_W    = 128,
    parameter int ST_W     = 2,
    localparam int TIDX_W  = $clog2(NUM_TAGS),
    localparam int STAG_W  = BLK_AW - MIDX_W,
    localparam int OUT_W   = LANES * SUB_W
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [BLK_AW-1:0]                 req_addr,
    input  logic [NUM_TAGS*STAG_W-1:0]        tag_addr,
    input  logic [NUM_TAGS*MEMBERS*ST_W-1:0]  tag_state,
    input  logic [NUM_TAGS*MEMBERS-1:0]       tag_comp,
    input  logic [NUM_SUBS-1:0]               bp_valid,
    input  logic [NUM_SUBS*TIDX_W-1:0]        bp_tag,
    input  logic [NUM_SUBS*MIDX_W-1:0]        bp_blk,
    input  logic [NUM_SUBS*SUB_W-1:0]         sub_data,
    output logic                              rsp_valid,
    output logic                              rsp_hit,
    output logic                              rsp_comp,
    output logic [LANES-1:0]                  rsp_lane_vld,
    output logic [OUT_W-1:0]                  rsp_data,
    output logic                              rsp_err
);
    sel_state_t state_q, state_d;

    logic              cmp_hit;
    logic [TIDX_W-1:0] cmp_tidx;
    logic              cmp_comp;
    logic [NUM_SUBS-1:0] cmp_match;

    logic                s_hit;
    logic                s_comp;
    logic [NUM_SUBS-1:0] s_match;

    logic [LANES-1:0] g_lane_vld;
    logic [OUT_W-1:0] g_data;
    logic             g_err;

    sbc_tag_match #(
        .NUM_TAGS (NUM_TAGS),
        .BLK_AW   (BLK_AW),
        .ST_W     (ST_W)
    ) u_tag (
        .addr_i      (req_addr),
        .tag_addr_i  (tag_addr),
        .tag_state_i (tag_state),
        .tag_comp_i  (tag_comp),
        .hit_o       (cmp_hit),
        .tidx_o      (cmp_tidx),
        .comp_o      (cmp_comp)
    );

    sbc_bp_match #(
        .NUM_TAGS (NUM_TAGS),
        .NUM_SUBS (NUM_SUBS)
    ) u_bp (
        .en_i       (cmp_hit),
        .tidx_i     (cmp_tidx),
        .midx_i     (req_addr[MIDX_W-1:0]),
        .bp_valid_i (bp_valid),
        .bp_tag_i   (bp_tag),
        .bp_blk_i   (bp_blk),
        .match_o    (cmp_match)
    );

    sbc_gather #(
        .NUM_SUBS (NUM_SUBS),
        .SUB_W    (SUB_W)
    ) u_gather (
        .hit_i      (s_hit),
        .comp_i     (s_comp),
        .match_i    (s_match),
        .sub_data_i (sub_data),
        .lane_vld_o (g_lane_vld),
        .data_o     (g_data),
        .err_o      (g_err)
    );

    // Next-state logic of the lookup controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_SELECT : ST_IDLE;
            ST_SELECT: state_d = req_valid ? ST_SELECT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Compare stage: registered slot mask of the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_hit   <= 1'b0;
            s_comp  <= 1'b0;
            s_match <= '0;
        end else if (req_valid) begin
            s_hit   <= cmp_hit;
            s_comp  <= cmp_comp;
            s_match <= cmp_match;
        end
    end

    // Output process: loads the gathered response in the select state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_comp     <= 1'b0;
            rsp_lane_vld <= '0;
            rsp_data     <= '0;
            rsp_err      <= 1'b0;
        end else begin
            rsp_valid <= (state_q == ST_SELECT);
            if (state_q == ST_SELECT) begin
                rsp_hit      <= s_hit;
                rsp_comp     <= s_comp;
                rsp_lane_vld <= g_lane_vld;
                rsp_data     <= g_data;
                rsp_err      <= g_err;
            end
        end
    end
endmodule

// File: rtl/sbc_lookup_chk.sv
module sbc_lookup_chk #(
    parameter int DATA_W = 512
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_comp,
    input logic [3:0]        rsp_lane_vld,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_err
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_resp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

    assert_miss_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_lane_vld == 4'h0 && !rsp_err && !rsp_comp && rsp_data == '0));

    assert_lane_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_lane_vld == 4'h0 || rsp_lane_vld == 4'h1 || rsp_lane_vld == 4'h3 ||
        rsp_lane_vld == 4'h7 || rsp_lane_vld == 4'hF);

    assert_uncomp_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_comp && !rsp_err) |-> (rsp_lane_vld == 4'hF));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(rsp_hit) && $stable(rsp_comp) && $stable(rsp_lane_vld) &&
                        $stable(rsp_data) && $stable(rsp_err)));
endmodule

bind sbc_lookup sbc_lookup_chk #(.DATA_W(OUT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_comp     (rsp_comp),
    .rsp_lane_vld (rsp_lane_vld),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err)
);

// File: tb/sbc_lookup_test.sv
`timescale 1ns/1ps
module sbc_lookup_test;
    localparam int NT = 16;
    localparam int NS = 64;
    localparam int SW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [NT*30-1:0] tag_addr = '0;
    logic [NT*8-1:0]  tag_state = '0;
    logic [NT*4-1:0]  tag_comp = '0;
    logic [NS-1:0]    bp_valid = '0;
    logic [NS*4-1:0]  bp_tag = '0;
    logic [NS*2-1:0]  bp_blk = '0;
    logic [NS*SW-1:0] sub_data = '0;
    logic rsp_valid, rsp_hit, rsp_comp, rsp_err;
    logic [3:0]   rsp_lane_vld;
    logic [511:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    sbc_lookup uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .tag_addr(tag_addr), .tag_state(tag_state), .tag_comp(tag_comp),
        .bp_valid(bp_valid), .bp_tag(bp_tag), .bp_blk(bp_blk), .sub_data(sub_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_comp(rsp_comp),
        .rsp_lane_vld(rsp_lane_vld), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state
    bit pend;
    bit pend_hit, pend_comp;
    int pend_slots[$];
    bit e_valid, e_hit, e_comp, e_err;
    logic [3:0]   e_lane;
    logic [511:0] e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend = 0; pend_hit = 0; pend_comp = 0; pend_slots.delete();
            e_valid = 0; e_hit = 0; e_comp = 0; e_err = 0; e_lane = '0; e_data = '0;
        end else begin
            e_valid = pend;
            if (pend) begin
                int n;
                n = pend_slots.size();
                e_hit = pend_hit;
                e_comp = pend_comp;
                e_lane = '0;
                e_data = '0;
                for (int i = 0; i < n && i < 4; i++) begin
                    e_lane[i] = 1'b1;
                    e_data[i*SW +: SW] = sub_data[pend_slots[i]*SW +: SW];
                end
                e_err = pend_hit && (n > 4 || (!pend_comp && n != 4));
            end
            pend = req_valid;
            if (req_valid) begin
                int m, ti;
                m = int'(req_addr[1:0]);
                pend_hit = 0; pend_comp = 0; ti = 0;
                pend_slots.delete();
                for (int t = 0; t < NT; t++) begin
                    if (!pend_hit && tag_addr[t*30 +: 30] == req_addr[31:2] &&
                        tag_state[(t*4+m)*2 +: 2] != 2'b00) begin
                        pend_hit = 1; ti = t; pend_comp = tag_comp[t*4+m];
                    end
                end
                if (pend_hit)
                    for (int s = 0; s < NS; s++)
                        if (bp_valid[s] && int'(bp_tag[s*4 +: 4]) == ti && int'(bp_blk[s*2 +: 2]) == m)
                            pend_slots.push_back(s);
            end
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R3 rsp_valid", 512'(rsp_valid), 512'(e_valid));
            if (rsp_valid) begin
                chk("R1 R2 rsp_hit", 512'(rsp_hit), 512'(e_hit));
                chk("R6 rsp_comp", 512'(rsp_comp), 512'(e_comp));
                chk("R4 R7 rsp_lane_vld", 512'(rsp_lane_vld), 512'(e_lane));
                chk("R4 R5 R7 rsp_data", rsp_data, e_data);
                chk("R8 rsp_err", 512'(rsp_err), 512'(e_err));
            end else begin
                chk("R10 hold", {rsp_data, rsp_lane_vld, rsp_hit, rsp_comp, rsp_err},
                                {e_data, e_lane, e_hit, e_comp, e_err});
            end
        end
    end

    task automatic set_state(input int t, input int m, input logic [1:0] st, input bit c);
        tag_state[(t*4+m)*2 +: 2] = st;
        tag_comp[t*4+m] = c;
    endtask

    task automatic set_bp(input int s, input int t, input int m, input bit v);
        bp_valid[s] = v;
        bp_tag[s*4 +: 4] = 4'(t);
        bp_blk[s*2 +: 2] = 2'(m);
    endtask

    task automatic fill_data();
        for (int w = 0; w < NS*SW/32; w++) sub_data[w*32 +: 32] = $urandom;
    endtask

    task automatic do_req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    localparam logic [29:0] SA = 30'h0ABCDE;
    localparam logic [29:0] SB = 30'h0012345;

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs are zero during reset
        chk("R9 reset", {rsp_data, rsp_lane_vld, rsp_valid, rsp_hit, rsp_comp, rsp_err}, '0);
        #1 rst_n = 1'b1;
        cmp_on = 1;

        // Hand-built set
        tag_addr[2*30 +: 30] = SA;
        tag_addr[3*30 +: 30] = SA;
        tag_addr[9*30 +: 30] = SB;
        for (int t = 0; t < NT; t++)
            if (t != 2 && t != 3 && t != 9) tag_addr[t*30 +: 30] = 30'h3000000 + 30'(t);
        set_state(3, 0, 2'd1, 1); set_state(3, 1, 2'd0, 0);
        set_state(3, 2, 2'd2, 0); set_state(3, 3, 2'd3, 1);
        set_state(2, 1, 2'd2, 0);
        set_state(9, 0, 2'd1, 1);
        set_bp(40, 3, 0, 1); set_bp(7, 3, 0, 1);
        set_bp(60, 3, 2, 1); set_bp(2, 3, 2, 1); set_bp(33, 3, 2, 1); set_bp(15, 3, 2, 1);
        set_bp(1, 3, 3, 1); set_bp(5, 3, 3, 1); set_bp(9, 3, 3, 1); set_bp(11, 3, 3, 1); set_bp(50, 3, 3, 1);
        set_bp(20, 2, 1, 1); set_bp(21, 2, 1, 1); set_bp(22, 2, 1, 1);
        set_bp(30, 3, 1, 1); set_bp(31, 3, 0, 0); set_bp(45, 4, 0, 1);
        fill_data();

        // Isolated requests
        do_req({SA, 2'd0}); idle(3);  // R2 skip invalid tag 2, compressed two lanes
        do_req({SA, 2'd1}); idle(3);  // R2 tag 2 wins, three slots uncompressed: R8
        do_req({SA, 2'd2}); idle(3);  // R4 full uncompressed, out of order
        do_req({SA, 2'd3}); idle(3);  // R8 five matches
        do_req({SB, 2'd0}); idle(3);  // compressed, no slots
        do_req({SB, 2'd1}); idle(3);  // R7 invalid member
        do_req(32'hDEAD_BEE0); idle(3); // R7 unknown address

        // Back-to-back requests (R3)
        do_req({SA, 2'd2}); do_req({SB, 2'd1}); do_req({SA, 2'd0});
        do_req({SA, 2'd3}); do_req({SA, 2'd1});
        idle(3);

        // R5: data changes between request edge and selection edge
        do_req({SA, 2'd2});
        @(negedge clk);
        req_valid = 1'b0;
        fill_data();
        idle(3);

        // Random traffic
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (cyc % 25 == 0) begin
                logic [29:0] pool [4];
                for (int p = 0; p < 4; p++) pool[p] = 30'($urandom);
                for (int t = 0; t < NT; t++) tag_addr[t*30 +: 30] = pool[$urandom % 4];
                tag_state = {4{$urandom}};
                tag_comp  = {$urandom, $urandom};
                for (int s = 0; s < NS; s++) set_bp(s, $urandom % 4, $urandom % 4, 1'($urandom));
            end
            if ($urandom % 3 == 0) fill_data();
            req_valid = ($urandom % 10) < 7;
            if ($urandom % 8 == 0) req_addr = $urandom;
            else req_addr = {tag_addr[($urandom % NT)*30 +: 30], 2'($urandom)};
        end
        idle(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule